// File: doc/BRIEF.md
# Direct-Page Indirect Address Sequencer

This block runs the bus cycles of three pointer-through-direct-page addressing forms for a 16-bit extension of a classic 8-bit processor. The three forms are:

- a 16-bit pointer, completed with the data bank register and offset by Y;
- a 24-bit pointer offset by Y;
- a 24-bit pointer used as it is.

When idle, the sequencer takes a pulse on `start` together with an opcode. It then emits one bus cycle per clock. It fetches the one-byte offset at the program counter, and may insert an internal cycle. It reads the pointer bytes out of bank 0. For the short Y form it may issue a throwaway read. It finishes with one or two data accesses.

Each bus byte read is returned combinationally on `readData` in the same cycle and captured at the clock edge that ends the cycle. The processor core keeps its registers stable while the sequencer is busy. It increments its program counter when `pcStep` is high. It performs the arithmetic operation itself when the data cycles take place.

Top module: `dp_indirect_seq`

## Requirements
- R1: After reset, `busy`, `busValid`, `busRead`, `busWrite`, `pcStep` and `done` are all low, and they stay low until an opcode is accepted.
- R2: The first cycle after an opcode is accepted is a read of the offset byte at address {8'h00, progCounter}, with `pcStep` high. `pcStep` is high in no other cycle.
- R3: If directPage[7:0] is nonzero, the next cycle is an internal cycle: `busValid` is high, `busRead` and `busWrite` are low, and the address is {8'h00, progCounter}. If directPage[7:0] is zero, this cycle is left out.
- R4: The pointer base is (directPage + offset) mod 2^16 in bank 0. The pointer bytes are read at base, base+1 and base+2, each wrapping within 16 bits. The short form reads only the first two bytes; the long forms read all three (low, middle, bank).
- R5: Bits [4:0] of the opcode select the form. 5'b10001 selects the short Y form, 5'b10111 the long Y form, and 5'b00111 the plain long form. Any other opcode on `start` produces no bus cycle and leaves `busy` low.
- R6: In the short Y form, the data address is {dataBank, ptrHigh, ptrLow} + Y, computed over all 24 bits so that a carry reaches the bank byte. When indexWide is 0, only Y[7:0] is used.
- R7: In the short Y form, a read at {dataBank, ptrHigh, (ptrLow + Y[7:0]) mod 256} follows the pointer fetch. It is left out only for a load with indexWide 0 when ptrLow + Y[7:0] stays below 256.
- R8: In the long Y form, the data address is the fetched 24-bit pointer plus Y (masked to 8 bits when indexWide is 0), wrapping at 24 bits. In the plain long form, the data address is the fetched pointer itself.
- R9: With dataWide 0 there is one data cycle. With dataWide 1 there are two, at the data address and the data address + 1 (24-bit). Opcodes whose upper nibble is 8 or 9 are stores and drive `busWrite`. All other opcodes drive `busRead`. `busRead` and `busWrite` are never high together.
- R10: `done` is high exactly in the last data cycle, and `busy` is low in the following cycle. A `start` that arrives while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to begin a sequence for `opcode` |
| opcode | input | 8 | Opcode of the instruction |
| directPage | input | 16 | Direct-page register |
| dataBank | input | 8 | Data bank register |
| yIndex | input | 16 | Y index register |
| progCounter | input | 16 | Program counter, pointing at the offset byte |
| indexWide | input | 1 | 1 selects 16-bit index registers |
| dataWide | input | 1 | 1 selects 16-bit data |
| readData | input | 8 | Byte returned by the bus in the current cycle |
| busAddr | output | 24 | Bus address of the current cycle |
| busValid | output | 1 | A cycle (memory or internal) is in progress |
| busRead | output | 1 | The current cycle reads memory |
| busWrite | output | 1 | The current cycle writes memory |
| pcStep | output | 1 | The program counter is to be incremented |
| done | output | 1 | Last data cycle of the sequence |
| busy | output | 1 | A sequence is in progress |

## Verification
The hardest case to reach is the throwaway read in the short Y form. Whether it appears depends jointly on the access direction, the index width and a carry out of a pointer byte that only memory supplies.

The bench memory returns a byte that is a fixed function of the address. The driver derives the offset, the pointer and the page carry from that same function, so its expected cycle list always matches the pointer the design actually reads. The cases are Y = 0 (no carry), Y = 0xFF (carry), a store, and 16-bit index mode.

A second `start` pulse is injected in the middle of a sequence, and undecoded opcodes are sent, to confirm that neither produces any bus cycle.

// File: rtl/dpi_pkg.sv
package dpi_pkg;
  localparam int ADDR_W = 24;
  localparam int WORD_W = 16;
  localparam int BYTE_W = ADDR_W - WORD_W;

  typedef enum logic [2:0] {
    SEL_PC, SEL_PTR0, SEL_PTR1, SEL_PTR2, SEL_DUMMY, SEL_DATA0, SEL_DATA1
  } addrSel_e;

  typedef struct packed {
    addrSel_e addrSel;
    logic     capOffset;
    logic     capLow;
    logic     capMid;
    logic     capBank;
  } pathCtl_t;

  typedef enum logic [3:0] {
    ST_IDLE, ST_OFFS, ST_INT, ST_PLO, ST_PMID, ST_PBANK, ST_DUMMY, ST_DLO, ST_DHI
  } seqState_e;

  typedef enum logic [1:0] {MODE_IND_Y, MODE_LONG_Y, MODE_LONG} dpMode_e;
endpackage

// File: rtl/dpi_ctrl.sv
module dpi_ctrl
  import dpi_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  input  logic [7:0] opcode,
  input  logic     dpLowZero,
  input  logic     indexWide,
  input  logic     dataWide,
  input  logic     pageCross,
  output pathCtl_t ctl,
  output logic     modeLong,
  output logic     modeIndexed,
  output logic     idxWideQ,
  output logic     busValid,
  output logic     busRead,
  output logic     busWrite,
  output logic     pcStep,
  output logic     done,
  output logic     busy
);
  seqState_e state;
  dpMode_e   mode;
  logic      isStore, wideQ;
  logic      opValid;
  dpMode_e   opMode;

  always_comb begin
    opValid = 1'b1;
    opMode  = MODE_LONG;
    unique case (opcode[4:0])
      5'b10001: opMode = MODE_IND_Y;
      5'b10111: opMode = MODE_LONG_Y;
      5'b00111: opMode = MODE_LONG;
      default:  opValid = 1'b0;
    endcase
  end

  wire needDummy = isStore | idxWideQ | pageCross;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      mode     <= MODE_LONG;
      isStore  <= 1'b0;
      wideQ    <= 1'b0;
      idxWideQ <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (start && opValid) begin
          state    <= ST_OFFS;
          mode     <= opMode;
          isStore  <= (opcode[7:5] == 3'b100);
          wideQ    <= dataWide;
          idxWideQ <= indexWide;
        end
        ST_OFFS:  state <= dpLowZero ? ST_PLO : ST_INT;
        ST_INT:   state <= ST_PLO;
        ST_PLO:   state <= ST_PMID;
        ST_PMID:  state <= (mode != MODE_IND_Y) ? ST_PBANK
                         : (needDummy ? ST_DUMMY : ST_DLO);
        ST_PBANK: state <= ST_DLO;
        ST_DUMMY: state <= ST_DLO;
        ST_DLO:   state <= wideQ ? ST_DHI : ST_IDLE;
        ST_DHI:   state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  assign modeLong    = (mode != MODE_IND_Y);
  assign modeIndexed = (mode != MODE_LONG);
  assign busy        = (state != ST_IDLE);

  always_comb begin
    ctl      = '{addrSel: SEL_PC, default: 1'b0};
    busValid = 1'b1;
    busRead  = 1'b1;
    busWrite = 1'b0;
    pcStep   = 1'b0;
    done     = 1'b0;
    unique case (state)
      ST_OFFS:  begin pcStep = 1'b1; ctl.capOffset = 1'b1; end
      ST_INT:   busRead = 1'b0;
      ST_PLO:   begin ctl.addrSel = SEL_PTR0; ctl.capLow  = 1'b1; end
      ST_PMID:  begin ctl.addrSel = SEL_PTR1; ctl.capMid  = 1'b1; end
      ST_PBANK: begin ctl.addrSel = SEL_PTR2; ctl.capBank = 1'b1; end
      ST_DUMMY: ctl.addrSel = SEL_DUMMY;
      ST_DLO: begin
        ctl.addrSel = SEL_DATA0;
        busRead = ~isStore; busWrite = isStore; done = ~wideQ;
      end
      ST_DHI: begin
        ctl.addrSel = SEL_DATA1;
        busRead = ~isStore; busWrite = isStore; done = 1'b1;
      end
      default: begin busValid = 1'b0; busRead = 1'b0; end
    endcase
  end
endmodule

// File: rtl/dpi_path.sv
module dpi_path
  import dpi_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  pathCtl_t          ctl,
  input  logic [BYTE_W-1:0] readData,
  input  logic [WORD_W-1:0] directPage,
  input  logic [BYTE_W-1:0] dataBank,
  input  logic [WORD_W-1:0] yIndex,
  input  logic [WORD_W-1:0] progCounter,
  input  logic              modeLong,
  input  logic              modeIndexed,
  input  logic              idxWide,
  output logic              pageCross,
  output logic [ADDR_W-1:0] busAddr
);
  logic [BYTE_W-1:0] offsetQ, lowQ, midQ, bankQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      offsetQ <= '0; lowQ <= '0; midQ <= '0; bankQ <= '0;
    end else begin
      if (ctl.capOffset) offsetQ <= readData;
      if (ctl.capLow)    lowQ    <= readData;
      if (ctl.capMid)    midQ    <= readData;
      if (ctl.capBank)   bankQ   <= readData;
    end
  end

  logic [WORD_W-1:0] ptrBase;
  logic [ADDR_W-1:0] ptrFull, yExt, effAddr, dummyAddr;
  logic [BYTE_W:0]   lowSum;

  always_comb begin
    ptrBase   = directPage + {{(WORD_W-BYTE_W){1'b0}}, offsetQ};
    ptrFull   = {(modeLong ? bankQ : dataBank), midQ, lowQ};
    yExt      = {{(ADDR_W-WORD_W){1'b0}},
                 (idxWide ? yIndex[WORD_W-1:BYTE_W] : {BYTE_W{1'b0}}),
                 yIndex[BYTE_W-1:0]};
    effAddr   = modeIndexed ? ptrFull + yExt : ptrFull;
    lowSum    = {1'b0, lowQ} + {1'b0, yIndex[BYTE_W-1:0]};
    pageCross = lowSum[BYTE_W];
    dummyAddr = {ptrFull[ADDR_W-1:BYTE_W], lowSum[BYTE_W-1:0]};
    unique case (ctl.addrSel)
      SEL_PTR0:  busAddr = {{BYTE_W{1'b0}}, ptrBase};
      SEL_PTR1:  busAddr = {{BYTE_W{1'b0}}, ptrBase + WORD_W'(1)};
      SEL_PTR2:  busAddr = {{BYTE_W{1'b0}}, ptrBase + WORD_W'(2)};
      SEL_DUMMY: busAddr = dummyAddr;
      SEL_DATA0: busAddr = effAddr;
      SEL_DATA1: busAddr = effAddr + ADDR_W'(1);
      default:   busAddr = {{BYTE_W{1'b0}}, progCounter};
    endcase
  end
endmodule

// File: rtl/dp_indirect_seq.sv
module dp_indirect_seq
  import dpi_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [7:0]        opcode,
  input  logic [WORD_W-1:0] directPage,
  input  logic [BYTE_W-1:0] dataBank,
  input  logic [WORD_W-1:0] yIndex,
  input  logic [WORD_W-1:0] progCounter,
  input  logic              indexWide,
  input  logic              dataWide,
  input  logic [BYTE_W-1:0] readData,
  output logic [ADDR_W-1:0] busAddr,
  output logic              busValid,
  output logic              busRead,
  output logic              busWrite,
  output logic              pcStep,
  output logic              done,
  output logic              busy
);
  pathCtl_t ctl;
  logic modeLong, modeIndexed, idxWideQ, pageCross;

  dpi_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .opcode(opcode),
    .dpLowZero(directPage[BYTE_W-1:0] == '0),
    .indexWide(indexWide), .dataWide(dataWide), .pageCross(pageCross),
    .ctl(ctl), .modeLong(modeLong), .modeIndexed(modeIndexed),
    .idxWideQ(idxWideQ), .busValid(busValid), .busRead(busRead),
    .busWrite(busWrite), .pcStep(pcStep), .done(done), .busy(busy)
  );

  dpi_path u_path (
    .clk(clk), .rstN(rstN), .ctl(ctl), .readData(readData),
    .directPage(directPage), .dataBank(dataBank), .yIndex(yIndex),
    .progCounter(progCounter), .modeLong(modeLong),
    .modeIndexed(modeIndexed), .idxWide(idxWideQ),
    .pageCross(pageCross), .busAddr(busAddr)
  );
endmodule

// File: rtl/dp_indirect_seq_chk.sv
module dp_indirect_seq_chk (
  input logic clk,
  input logic rstN,
  input logic busValid,
  input logic busRead,
  input logic busWrite,
  input logic pcStep,
  input logic done,
  input logic busy
);
  // R9
  rw_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(busRead && busWrite));

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !(busValid || pcStep || done));

  // R2
  pc_step_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    pcStep |-> (busValid && busRead));

  // R2
  pc_step_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> pcStep);

  // R10
  done_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (busValid && (busRead || busWrite)));

  // R10
  done_ends_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);
endmodule

bind dp_indirect_seq dp_indirect_seq_chk u_chk (
  .clk(clk), .rstN(rstN), .busValid(busValid), .busRead(busRead),
  .busWrite(busWrite), .pcStep(pcStep), .done(done), .busy(busy)
);

// File: tb/dp_indirect_seq_test.sv
module dp_indirect_seq_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [7:0] opcode = 8'h00;
  logic [15:0] directPage = 16'h0;
  logic [7:0] dataBank = 8'h0;
  logic [15:0] yIndex = 16'h0;
  logic [15:0] progCounter = 16'h0;
  logic indexWide = 1'b0;
  logic dataWide = 1'b0;
  logic [7:0] readData;
  logic [23:0] busAddr;
  logic busValid, busRead, busWrite, pcStep, done, busy;

  always #2.5 clk = ~clk;

  dp_indirect_seq uut (
    .clk(clk), .rstN(rstN), .start(start), .opcode(opcode),
    .directPage(directPage), .dataBank(dataBank), .yIndex(yIndex),
    .progCounter(progCounter), .indexWide(indexWide), .dataWide(dataWide),
    .readData(readData), .busAddr(busAddr), .busValid(busValid),
    .busRead(busRead), .busWrite(busWrite), .pcStep(pcStep),
    .done(done), .busy(busy)
  );

  function automatic logic [7:0] memByte(input logic [23:0] a);
    return a[7:0] * 8'd7 + a[15:8] + a[23:16] * 8'd3 + 8'h13;
  endfunction

  assign readData = memByte(busAddr);

  typedef struct {
    logic [23:0] addr;
    logic rd, wr, step, fin;
    string tag;
  } cyc_t;

  cyc_t expQ[$];
  int tests = 0;
  int fails = 0;

  task automatic push(input logic [23:0] a, input logic rd, input logic wr,
                      input logic st, input logic fin, input string tag);
    cyc_t c;
    c.addr = a; c.rd = rd; c.wr = wr; c.step = st; c.fin = fin; c.tag = tag;
    expQ.push_back(c);
  endtask

  // monitor: compare each valid cycle against the scoreboard
  always @(negedge clk) begin
    if (rstN && busValid) begin
      tests++;
      if (expQ.size() == 0) begin
        fails++;
        $display("FAIL R5/R10 unexpected cycle: actual addr=%h rd=%b wr=%b expected none",
                 busAddr, busRead, busWrite);
      end else begin
        cyc_t e;
        e = expQ.pop_front();
        if (busAddr !== e.addr || busRead !== e.rd || busWrite !== e.wr ||
            pcStep !== e.step || done !== e.fin) begin
          fails++;
          $display("FAIL %s: actual addr=%h rd=%b wr=%b step=%b done=%b expected addr=%h rd=%b wr=%b step=%b done=%b",
                   e.tag, busAddr, busRead, busWrite, pcStep, done,
                   e.addr, e.rd, e.wr, e.step, e.fin);
        end
      end
    end
  end

  task automatic check(input logic cond, input string msg);
    tests++;
    if (!cond) begin
      fails++;
      $display("FAIL %s", msg);
    end
  endtask

  task automatic runOp(input logic [7:0] op, input logic [15:0] dp,
                       input logic [7:0] dbr, input logic [15:0] y,
                       input logic [15:0] pc, input logic xw, input logic mw,
                       input logic poke);
    logic store;
    logic [7:0] off, lo, mid, bk;
    logic [15:0] base, yv;
    logic [23:0] ptr, eff;
    logic [8:0] lsum;
    store = (op[7:4] == 4'h8) || (op[7:4] == 4'h9);
    // R2 offset fetch
    push({8'h00, pc}, 1'b1, 1'b0, 1'b1, 1'b0, "R2 offset");
    // R3 internal cycle
    if (dp[7:0] != 8'h00) push({8'h00, pc}, 1'b0, 1'b0, 1'b0, 1'b0, "R3 internal");
    off  = memByte({8'h00, pc});
    base = dp + {8'h00, off};
    // R4 pointer bytes
    push({8'h00, base}, 1'b1, 1'b0, 1'b0, 1'b0, "R4 ptr low");
    lo = memByte({8'h00, base});
    push({8'h00, base + 16'd1}, 1'b1, 1'b0, 1'b0, 1'b0, "R4 ptr mid");
    mid = memByte({8'h00, base + 16'd1});
    yv = xw ? y : {8'h00, y[7:0]};
    if (op[4:0] == 5'b10001) begin
      ptr  = {dbr, mid, lo};
      eff  = ptr + {8'h00, yv};
      lsum = {1'b0, lo} + {1'b0, y[7:0]};
      // R7 throwaway read
      if (store || xw || lsum[8])
        push({ptr[23:8], lsum[7:0]}, 1'b1, 1'b0, 1'b0, 1'b0, "R7 dummy");
    end else begin
      push({8'h00, base + 16'd2}, 1'b1, 1'b0, 1'b0, 1'b0, "R4 ptr bank");
      bk  = memByte({8'h00, base + 16'd2});
      ptr = {bk, mid, lo};
      eff = op[4] ? ptr + {8'h00, yv} : ptr;
    end
    // R6 R8 R9 R10 data cycles
    push(eff, !store, store, 1'b0, !mw, "R6/R8/R9 data");
    if (mw) push(eff + 24'd1, !store, store, 1'b0, 1'b1, "R9 data high");

    @(negedge clk);
    opcode = op; directPage = dp; dataBank = dbr; yIndex = y;
    progCounter = pc; indexWide = xw; dataWide = mw; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      // R10 start while busy must be ignored
      opcode = 8'hB7; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (expQ.size() != 0) @(negedge clk);
    @(negedge clk);
    check(busy == 1'b0, "R10 busy low after done");
    repeat (2) @(negedge clk);
  endtask

  task automatic runIgnored(input logic [7:0] op);
    @(negedge clk);
    opcode = op; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    check(busy == 1'b0 && busValid == 1'b0,
          $sformatf("R5 opcode %h ignored: actual busy=%b expected 0", op, busy));
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(busy == 1'b0 && busValid == 1'b0 && pcStep == 1'b0 && done == 1'b0,
          "R1 outputs during reset");
    rstN = 1'b1;
    @(negedge clk);
    check(busy == 1'b0 && busValid == 1'b0 && busRead == 1'b0 && busWrite == 1'b0,
          "R1 idle after reset");
    // short Y form, load, DP low zero, 8-bit index, no carry
    runOp(8'hB1, 16'h1200, 8'h04, 16'h0000, 16'h0340, 1'b0, 1'b0, 1'b0);
    // short Y form with page carry and internal cycle
    runOp(8'h31, 16'h1234, 8'h7F, 16'h00FF, 16'h2001, 1'b0, 1'b1, 1'b0);
    // short Y form store, dummy always
    runOp(8'h91, 16'h0500, 8'hFF, 16'h0002, 16'h0777, 1'b0, 1'b1, 1'b0);
    // short Y form, 16-bit index, carry into bank
    runOp(8'hD1, 16'h0010, 8'h22, 16'hFFF0, 16'h4444, 1'b1, 1'b0, 1'b0);
    // long Y form, 16-bit index
    runOp(8'hB7, 16'h0001, 8'h00, 16'hFFFF, 16'h0100, 1'b1, 1'b1, 1'b0);
    // long Y form, 8-bit index masks Y high byte, store
    runOp(8'h97, 16'h3300, 8'h00, 16'hAB10, 16'h0909, 1'b0, 1'b0, 1'b0);
    // plain long, with start poked while busy
    runOp(8'h07, 16'h00C0, 8'h55, 16'h1234, 16'h0ABC, 1'b1, 1'b1, 1'b1);
    // plain long store, pointer base wrapping at 0xFFFF
    runOp(8'h87, 16'hFFFF, 8'h00, 16'h0000, 16'h0003, 1'b0, 1'b0, 1'b0);
    // undecoded opcodes
    runIgnored(8'h12);
    runIgnored(8'hA5);
    runIgnored(8'h01);
    check(expQ.size() == 0, "R10 scoreboard drained");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule